// File: doc/BRIEF.md
# Loadable Program Counter Register

This block holds the 16-bit instruction address of a small CPU with an 8-bit data path and a 16-bit address bus. A sequencer steps it forward by one after each instruction fetch. For jumps, it loads a new address from the address bus. An active-low asynchronous clear brings it to zero at power-up, without waiting for a clock.

The word is built from four 4-bit counting slices. The lowest slice is always allowed to advance. Each higher slice may advance only when the slice below reports a carry, and a slice reports a carry only when it is allowed to advance and all of its own bits are ones.

The stored value leaves the block through three active-low output enables:
- one places the whole word on the address bus;
- one places the upper byte on the data bus;
- one places the lower byte on the data bus.

Each tri-state bus is modelled as a value output with a companion valid flag.

Top module: `pc_reg`

## Requirements
- R1: While `rst_ni` is low, the stored value is 0x0000 at once, with no clock edge needed. After release it stays 0x0000 until a load or a count occurs.
- R2: With `ld_ni` high and `cnt_i` high, the stored value rises by exactly 1 on the next rising clock edge.
- R3: With `ld_ni` low, the value on `addr_i` becomes the stored value on the next rising clock edge.
- R4: When `ld_ni` is low and `cnt_i` is high in the same cycle, the load wins. The stored value equals `addr_i` and is not incremented.
- R5: Counting from 0xFFFF gives 0x0000 on the next edge.
- R6: With `ld_ni` high and `cnt_i` low, the stored value does not change.
- R7: With `word_oe_ni` low, `addr_o` shows all 16 stored bits and `addr_vld_o` is 1. With it high, `addr_vld_o` is 0 and `addr_o` is 0x0000.
- R8: With `hi_oe_ni` low, `data_hi_o` shows stored bits 15:8 and `hi_vld_o` is 1. With it high, `hi_vld_o` is 0 and `data_hi_o` is 0x00.
- R9: With `lo_oe_ni` low, `data_lo_o` shows stored bits 7:0 and `lo_vld_o` is 1. With it high, `lo_vld_o` is 0 and `data_lo_o` is 0x00.
- R10: A 4-bit slice advances on a count only when every stored bit below it is 1. Examples: 0x000F goes to 0x0010, 0x0FFF goes to 0x1000, and 0x00F7 goes to 0x00F8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear to 0x0000 |
| ld_ni | input | 1 | Active-low load from the address bus (jump) |
| cnt_i | input | 1 | Increment by one on the clock edge |
| addr_i | input | 16 | Address bus value to load |
| word_oe_ni | input | 1 | Active-low enable of the full word onto the address bus |
| hi_oe_ni | input | 1 | Active-low enable of the upper byte onto the data bus |
| lo_oe_ni | input | 1 | Active-low enable of the lower byte onto the data bus |
| addr_o | output | 16 | Address bus drive, zero when not enabled |
| addr_vld_o | output | 1 | Address bus is driven |
| data_hi_o | output | 8 | Data bus drive of the upper byte, zero when not enabled |
| hi_vld_o | output | 1 | Upper byte is driven |
| data_lo_o | output | 8 | Data bus drive of the lower byte, zero when not enabled |
| lo_vld_o | output | 1 | Lower byte is driven |

## Verification
The hardest conditions to reach are the long carry chains, such as the wrap from 0xFFFF and the ripple out of 0x0FFF. Counting from zero would need tens of thousands of increments to get there. The stimulus instead loads values just below a slice boundary, then counts across it. Random loads also bias their low nibbles toward all ones, so carries happen often. A clear asserted in the middle of a cycle is checked before the next clock edge, which shows it acts without the clock.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_SLICE_W = 4;
  localparam int PC_SLICES  = 4;
endpackage

// File: rtl/pc_slice.sv
module pc_slice #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         pe_i,
  input  logic         te_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= '0;
    else if (load_i)          q_o <= d_i;
    else if (pe_i && te_i)    q_o <= q_o + W'(1);
  end

  // carry only when enabled from below and saturated
  assign rco_o = te_i & (&q_o);

  assert_slice_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(pe_i && te_i)) |=> $stable(q_o));
endmodule

// File: rtl/pc_bus_drv.sv
module pc_bus_drv #(
  parameter int W = 8
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         vld_o
);
  assign vld_o = ~oe_ni;
  assign q_o   = oe_ni ? '0 : d_i;
endmodule

// File: rtl/pc_reg.sv
module pc_reg
  import pc_pkg::*;
#(
  parameter int SLICE_W  = PC_SLICE_W,
  parameter int N_SLICES = PC_SLICES
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ld_ni,
  input  logic                           cnt_i,
  input  logic [SLICE_W*N_SLICES-1:0]    addr_i,
  input  logic                           word_oe_ni,
  input  logic                           hi_oe_ni,
  input  logic                           lo_oe_ni,
  output logic [SLICE_W*N_SLICES-1:0]    addr_o,
  output logic                           addr_vld_o,
  output logic [SLICE_W*N_SLICES/2-1:0]  data_hi_o,
  output logic                           hi_vld_o,
  output logic [SLICE_W*N_SLICES/2-1:0]  data_lo_o,
  output logic                           lo_vld_o
);
  localparam int W  = SLICE_W * N_SLICES;
  localparam int HW = W / 2;

  logic [W-1:0]        pc;
  logic [N_SLICES-1:0] te;
  logic [N_SLICES-1:0] rco;

  for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
    if (g == 0) begin : g_lsb
      assign te[g] = 1'b1;
    end else begin : g_up
      assign te[g] = rco[g-1];
    end
    pc_slice #(.W(SLICE_W)) u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (~ld_ni),
      .pe_i   (cnt_i),
      .te_i   (te[g]),
      .d_i    (addr_i[g*SLICE_W +: SLICE_W]),
      .q_o    (pc[g*SLICE_W +: SLICE_W]),
      .rco_o  (rco[g])
    );
  end

  pc_bus_drv #(.W(W)) u_word (
    .oe_ni (word_oe_ni), .d_i (pc), .q_o (addr_o), .vld_o (addr_vld_o)
  );
  pc_bus_drv #(.W(HW)) u_hi (
    .oe_ni (hi_oe_ni), .d_i (pc[W-1:HW]), .q_o (data_hi_o), .vld_o (hi_vld_o)
  );
  pc_bus_drv #(.W(HW)) u_lo (
    .oe_ni (lo_oe_ni), .d_i (pc[HW-1:0]), .q_o (data_lo_o), .vld_o (lo_vld_o)
  );

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && cnt_i) |=> pc == $past(pc) + W'(1));
  assert_load_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni) |=> pc == $past(addr_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && !cnt_i) |=> $stable(pc));
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni && cnt_i && rco[N_SLICES-1]) |=> pc == '0);
endmodule

// File: tb/tb_pc_reg.sv
`timescale 1ns/1ps
module tb_pc_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_ni = 1'b1, cnt_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        word_oe_ni = 1'b1, hi_oe_ni = 1'b1, lo_oe_ni = 1'b1;
  logic [15:0] addr_o;
  logic [7:0]  data_hi_o, data_lo_o;
  logic        addr_vld_o, hi_vld_o, lo_vld_o;

  int checks = 0, fails = 0;
  logic [15:0] m = '0;

  always #2.5 clk = ~clk;

  pc_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_ni(ld_ni), .cnt_i(cnt_i), .addr_i(addr_i),
    .word_oe_ni(word_oe_ni), .hi_oe_ni(hi_oe_ni), .lo_oe_ni(lo_oe_ni),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .data_hi_o(data_hi_o),
    .hi_vld_o(hi_vld_o), .data_lo_o(data_lo_o), .lo_vld_o(lo_vld_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(string req);
    logic [15:0] ew;
    logic [7:0] eh, el;
    ew = word_oe_ni ? 16'h0 : m;
    eh = hi_oe_ni ? 8'h0 : m[15:8];
    el = lo_oe_ni ? 8'h0 : m[7:0];
    chk({req, "/R7"}, {addr_vld_o, addr_o[14:0]} , {~word_oe_ni, ew[14:0]});
    chk({req, "/R7"}, {15'h0, addr_o[15]}, {15'h0, ew[15]});
    chk({req, "/R8"}, {7'h0, hi_vld_o, data_hi_o}, {7'h0, ~hi_oe_ni, eh});
    chk({req, "/R9"}, {7'h0, lo_vld_o, data_lo_o}, {7'h0, ~lo_oe_ni, el});
  endtask

  task automatic step(logic ld_n, logic cnt, logic [15:0] a,
                      logic woe, logic hoe, logic loe);
    string req;
    @(negedge clk);
    ld_ni = ld_n; cnt_i = cnt; addr_i = a;
    word_oe_ni = woe; hi_oe_ni = hoe; lo_oe_ni = loe;
    @(posedge clk);
    #1;
    if (!ld_n) begin m = a; req = cnt ? "R4" : "R3"; end
    else if (cnt) begin
      if (m == 16'hFFFF) req = "R5";
      else if (m[3:0] == 4'hF) req = "R10";
      else req = "R2";
      m = m + 16'd1;
    end else req = "R6";
    chk_outs(req);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    word_oe_ni = 1'b0; hi_oe_ni = 1'b0; lo_oe_ni = 1'b0;
    #1;
    chk_outs("R1");
    #10;
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk_outs("R1");
    // directed corners
    step(1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);           // R2
    step(1'b0, 1'b0, 16'h0FFF, 1'b0, 1'b0, 1'b0);        // R3
    step(1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);           // R10 -> 0x1000
    chk("R10", addr_o, 16'h1000);
    step(1'b0, 1'b0, 16'h00F7, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);           // R10 -> 0x00F8
    chk("R10", addr_o, 16'h00F8);
    step(1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);           // R5
    chk("R5", addr_o, 16'h0000);
    step(1'b0, 1'b1, 16'hA55A, 1'b0, 1'b0, 1'b0);        // R4
    chk("R4", addr_o, 16'hA55A);
    step(1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0);        // R6
    chk("R6", addr_o, 16'hA55A);
    step(1'b1, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1);           // R7 R8 R9 disabled
    step(1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);           // R8 alone
    step(1'b1, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0);           // R9 alone
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[3:0] = 4'hF;
      if ($urandom_range(0, 3) == 0) a[11:4] = 8'hFF;
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0), a,
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    // asynchronous clear mid-cycle
    step(1'b0, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    ld_ni = 1'b1; cnt_i = 1'b0;
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    m = '0;
    chk("R1", addr_o, 16'h0000);
    chk_outs("R1");
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", addr_o, 16'h0000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule